// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits between a receive byte stream and system memory. Bytes arrive one per cycle with a start marker on the first byte of a frame and an end marker on the last. The block scatters each frame across fixed-size memory buffers. The buffers are described by a ring of two-word descriptors that begins at a programmable base address.

For every buffer it fills, the block writes back a status word and the address word. The status word carries start and end marks, plus the frame length on the final piece. The address word has its ownership bit set, which hands the buffer to software. Software returns a buffer by clearing that bit.

A small byte queue absorbs the cycles spent on descriptor traffic. Three sticky event flags report a finished frame, a descriptor that was still owned by software, and a byte lost because the queue was full.

Memory is reached through a single-beat port. Writes take effect at the clock edge. Read data is valid in the cycle after the request.

Top module: `rxring_writer`

## Requirements
- R1: Frame bytes are written in arrival order, one byte per write, to the buffer address held in bits 31:2 of the descriptor address word plus the byte offset inside the buffer. Each byte write enables exactly one byte lane, the one selected by address bits 1:0.
- R2: After filling a buffer, the block rewrites that descriptor's address word with bit 0 (owned by software) set and all other bits unchanged, including the wrap bit at bit 1.
- R3: The status word (descriptor address + 4) has bit 14 set only on the first piece of a frame and bit 15 set only on the last piece. Bits 11:0 hold the total frame length in bytes on the last piece and are zero on every other piece. All other bits are zero.
- R4: A frame longer than BUF_BYTES (128) bytes continues in the following descriptor at address +8. Descriptors beyond the last one used are not touched.
- R5: After using a descriptor whose address word has bit 1 set, the next descriptor is the one at the ring base address.
- R6: If a fetched descriptor already has bit 0 set, status flag bit 1 is set and the rest of that frame is discarded. That descriptor is left unmodified and is retried for the next frame. Pieces already written keep no end mark.
- R7: A byte that arrives while the byte queue is full sets status flag bit 2, and the rest of that frame is discarded. The open buffer is closed without an end mark when the next frame starts, and the new frame goes to the next descriptor.
- R8: Status flag bit 0 is set when the last piece of a frame has been written back.
- R9: Status flags hold until a one is written to the matching bit of irq_clr. irq is high whenever any flag is set.
- R10: With rx_en low, incoming bytes are ignored, no memory access is made, and the descriptor pointer is reloaded from ring_base. Enabling resumes at the ring base.
- R11: Bytes that arrive outside a frame (with no start marker) are discarded without any memory access.
- R12: After reset, all status flags and irq are low and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; gates all queue and descriptor activity |
| ring_base | input | AW | Byte address of the first descriptor, 8-byte aligned |
| in_valid | input | 1 | Byte present on in_data |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| irq_clr | input | 3 | Write-one-to-clear for the status flags |
| irq_status | output | 3 | Bit 0 frame done, bit 1 descriptor unavailable, bit 2 overrun |
| irq | output | 1 | OR of the status flags |

## Verification
Each byte reaches memory in the cycle it leaves the queue, and a descriptor costs five cycles: an idle step, the read, the ownership check, the status write and the address write. The frame-done flag therefore rises one edge after the address-word write-back, at most FIFO_DEPTH plus six cycles after the end byte enters. Flag clears take effect at the next edge.

The bench drives and samples on falling edges. After every frame it waits a fixed settle window longer than that bound before reading memory or flags, and it checks a flag clear one cycle after driving it.

Overrun is provoked with a continuous byte burst. The following frame is located by scanning for the next start mark, so the check does not depend on the exact cycle the queue fills.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int USED_BIT  = 0;
   localparam int WRAP_BIT  = 1;
   localparam int SOF_BIT   = 14;
   localparam int EOF_BIT   = 15;
   localparam int IRQ_N     = 3;
   localparam int IRQ_DONE  = 0;
   localparam int IRQ_BNA   = 1;
   localparam int IRQ_OVR   = 2;

   typedef struct packed {
      logic       sof;
      logic       eof;
      logic [7:0] data;
   } rx_byte_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_CHECK, ST_DATA, ST_WSTAT, ST_WADDR, ST_DROP
   } wr_state_t;
endpackage

// File: rtl/rxr_fifo.sv
module rxr_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH == 1) begin : g_single
         logic         vld_q;
         logic [W-1:0] dat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else if (flush) begin
               vld_q <= 1'b0;
            end else begin
               if (pop) vld_q <= 1'b0;
               if (push) begin
                  vld_q <= 1'b1;
                  dat_q <= din;
               end
            end
         end
         assign dout  = dat_q;
         assign empty = !vld_q;
         assign full  = vld_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [W-1:0]  store [DEPTH];
         logic [PW-1:0] wp, rp;
         logic [CW-1:0] cnt;
         logic          do_push, do_pop;
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else if (flush) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
               if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
               if (do_push && !do_pop)      cnt <= cnt + CW'(1);
               else if (do_pop && !do_push) cnt <= cnt - CW'(1);
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) store[wp] <= din;
         end
         assign dout  = store[rp];
         assign empty = (cnt == '0);
         assign full  = (cnt == CW'(DEPTH));
      end
   endgenerate
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status,
   output logic         irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      status[i] <= 1'b0;
            else if (set[i]) status[i] <= 1'b1;
            else if (clr[i]) status[i] <= 1'b0;
         end
      end
   endgenerate
   assign irq = |status;
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter int AW        = 32,
   parameter int BUF_BYTES = 128,
   parameter int LEN_W     = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_en,
   input  logic [AW-1:0] ring_base,
   input  rx_byte_t      head,
   input  logic          head_vld,
   output logic          pop,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          set_done,
   output logic          set_bna
);
   localparam int OFF_W = $clog2(BUF_BYTES);

   wr_state_t        st, st_nx;
   logic [AW-1:0]    desc_ptr;
   logic [31:0]      addr_word;
   logic [OFF_W-1:0] frag_cnt;
   logic             frag_used, frag_sof, close_eof, in_frame;
   logic [LEN_W-1:0] frame_len, len_now;
   logic [AW-1:0]    byte_addr;
   logic [31:0]      stat_word;
   logic             last_slot;

   assign byte_addr = AW'({addr_word[31:2], 2'b00}) + AW'(frag_cnt);
   assign len_now   = head.sof ? LEN_W'(1) : frame_len + LEN_W'(1);
   assign last_slot = (frag_cnt == OFF_W'(BUF_BYTES - 1));

   always_comb begin
      stat_word          = '0;
      stat_word[SOF_BIT] = frag_sof;
      stat_word[EOF_BIT] = close_eof;
      if (close_eof) stat_word[LEN_W-1:0] = frame_len;
   end

   always_comb begin
      st_nx     = st;
      pop       = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_ptr;
      mem_be    = 4'hF;
      mem_wdata = '0;
      set_done  = 1'b0;
      set_bna   = 1'b0;
      case (st)
         ST_IDLE: if (rx_en && head_vld) begin
            if (head.sof || in_frame) st_nx = ST_FETCH;
            else                      pop   = 1'b1;
         end
         ST_FETCH: begin
            mem_req = 1'b1;
            st_nx   = ST_CHECK;
         end
         ST_CHECK: if (mem_rdata[USED_BIT]) begin
            set_bna = 1'b1;
            pop     = 1'b1;
            st_nx   = head.eof ? ST_IDLE : ST_DROP;
         end else begin
            st_nx = ST_DATA;
         end
         ST_DATA: if (head_vld) begin
            if (head.sof && frag_used) begin
               st_nx = ST_WSTAT;
            end else begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = byte_addr;
               mem_be    = 4'b0001 << byte_addr[1:0];
               mem_wdata = {4{head.data}};
               pop       = 1'b1;
               if (head.eof || last_slot) st_nx = ST_WSTAT;
            end
         end
         ST_WSTAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_ptr + AW'(4);
            mem_wdata = stat_word;
            st_nx     = ST_WADDR;
         end
         ST_WADDR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = addr_word | 32'h1;
            set_done  = close_eof;
            st_nx     = ST_IDLE;
         end
         ST_DROP: if (head_vld) begin
            if (head.sof) begin
               st_nx = ST_IDLE;
            end else begin
               pop = 1'b1;
               if (head.eof) st_nx = ST_IDLE;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         desc_ptr  <= '0;
         addr_word <= '0;
         frag_cnt  <= '0;
         frag_used <= 1'b0;
         frag_sof  <= 1'b0;
         close_eof <= 1'b0;
         in_frame  <= 1'b0;
         frame_len <= '0;
      end else if (!rx_en) begin
         st        <= ST_IDLE;
         desc_ptr  <= ring_base;
         in_frame  <= 1'b0;
         frag_used <= 1'b0;
      end else begin
         st <= st_nx;
         case (st)
            ST_CHECK: if (mem_rdata[USED_BIT]) begin
               in_frame <= 1'b0;
            end else begin
               addr_word <= mem_rdata;
               frag_cnt  <= '0;
               frag_used <= 1'b0;
               frag_sof  <= 1'b0;
            end
            ST_DATA: if (head_vld) begin
               if (head.sof && frag_used) begin
                  close_eof <= 1'b0;
               end else begin
                  frag_used <= 1'b1;
                  frag_cnt  <= frag_cnt + OFF_W'(1);
                  frame_len <= len_now;
                  close_eof <= head.eof;
                  if (head.sof) begin
                     frag_sof <= 1'b1;
                     in_frame <= 1'b1;
                  end
               end
            end
            ST_WADDR: begin
               desc_ptr  <= addr_word[WRAP_BIT] ? ring_base : desc_ptr + AW'(8);
               frag_used <= 1'b0;
               if (close_eof) in_frame <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
   import rxr_pkg::*;
#(
   parameter int AW         = 32,
   parameter int BUF_BYTES  = 128,
   parameter int LEN_W      = 12,
   parameter int FIFO_DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [AW-1:0]    ring_base,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_sof,
   input  logic             in_eof,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [3:0]       mem_be,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   input  logic [IRQ_N-1:0] irq_clr,
   output logic [IRQ_N-1:0] irq_status,
   output logic             irq
);
   localparam int BW = $bits(rx_byte_t);

   if (BUF_BYTES < 4 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least 4");
   end
   if (LEN_W < 1 || LEN_W > SOF_BIT) begin : g_bad_len
      $error("LEN_W must fit below the start-of-frame bit");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 1");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW must lie between 8 and 32");
   end

   rx_byte_t   in_b, head;
   logic       drop_q, accept, discard, push, pop, f_empty, f_full, set_ovr;
   logic       set_done, set_bna;
   logic [BW-1:0] head_bits;

   assign in_b    = '{sof: in_sof, eof: in_eof, data: in_data};
   assign accept  = in_valid && rx_en;
   assign discard = drop_q && !in_sof;
   assign push    = accept && !discard && !f_full;
   assign set_ovr = accept && !discard && f_full;
   assign head    = rx_byte_t'(head_bits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          drop_q <= 1'b0;
      else if (!rx_en)     drop_q <= 1'b0;
      else if (accept) begin
         if (discard)      drop_q <= !in_eof;
         else if (f_full)  drop_q <= !in_eof;
         else              drop_q <= 1'b0;
      end
   end

   rxr_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push), .din(in_b),
      .pop(pop), .dout(head_bits), .empty(f_empty), .full(f_full)
   );

   rxr_engine #(.AW(AW), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
      .head(head), .head_vld(!f_empty), .pop(pop),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .set_done(set_done), .set_bna(set_bna)
   );

   rxr_irq #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .set({set_ovr, set_bna, set_done}),
      .clr(irq_clr), .status(irq_status), .irq(irq)
   );
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk
   import rxr_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LEN_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_en,
   input logic             mem_req,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic [3:0]       mem_be,
   input logic [31:0]      mem_wdata,
   input logic [IRQ_N-1:0] irq_clr,
   input logic [IRQ_N-1:0] irq_status
);
   logic word_wr;
   assign word_wr = mem_req && mem_we && (mem_be == 4'hF);

   a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !mem_req);

   a_r2_used_on_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      (word_wr && !mem_addr[2]) |-> mem_wdata[USED_BIT]);

   a_r3_len_only_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (word_wr && mem_addr[2] && !mem_wdata[EOF_BIT]) |-> (mem_wdata[LEN_W-1:0] == '0));

   a_r1_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

   a_r4_desc_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr[2:0] == 3'b000));

   a_r8_done_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[IRQ_DONE]) |-> $past(word_wr && !mem_addr[2]));

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_sticky
         a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_status[i] && !irq_clr[i]) |=> irq_status[i]);
      end
   endgenerate
endmodule

bind rxring_writer rxring_writer_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
   .irq_clr(irq_clr), .irq_status(irq_status)
);

// File: tb/sim_rxring_writer.sv
`timescale 1ns/1ps
module sim_rxring_writer;
   localparam logic [31:0] RB   = 32'h100;
   localparam logic [31:0] BUFB = 32'h1000;
   localparam logic [31:0] SENT = 32'h5A5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic [31:0] ring_base = RB;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_data = 8'h0;
   logic        mem_req, mem_we, irq;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = 32'h0;
   logic [3:0]  mem_be;
   logic [2:0]  irq_clr = 3'b000, irq_status;

   logic [31:0] mem [0:4095];
   logic        tb_we = 1'b0;
   logic [31:0] tb_addr = 32'h0, tb_data = 32'h0;
   int          wr_count = 0;
   int          checks = 0, errors = 0;

   always #5 clk = ~clk;

   rxring_writer u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
      .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_clr(irq_clr),
      .irq_status(irq_status), .irq(irq)
   );

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         wr_count <= wr_count + 1;
      end else if (tb_we) begin
         mem[tb_addr[13:2]] <= tb_data;
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
   end

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[13:2]];
   endfunction
   function automatic logic [7:0] rd_byte(input logic [31:0] a);
      logic [31:0] w;
      w = mem[a[13:2]];
      return w[8*a[1:0] +: 8];
   endfunction
   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed * 29 + i * 7 + (i >> 3)) & 255);
   endfunction
   function automatic logic [31:0] bufa(input int k);
      return BUFB + 32'(128 * k);
   endfunction
   function automatic logic [31:0] desc(input int k);
      return RB + 32'(8 * k);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tb_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = a; tb_data = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); irq_clr = 3'b111;
      @(negedge clk); irq_clr = 3'b000;
   endtask

   task automatic init_ring(input int n);
      @(negedge clk); rx_en = 1'b0;
      for (int k = 0; k < n; k++) begin
         tb_write(desc(k), bufa(k) | ((k == n - 1) ? 32'h2 : 32'h0));
         tb_write(desc(k) + 4, SENT);
      end
      tb_write(desc(n), 32'h1);
      tb_write(desc(n) + 4, SENT);
      clear_flags();
      @(negedge clk); rx_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_frame(input int len, input int gap, input int seed, input bit nosof);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = pat(seed, i);
         in_sof = (i == 0) && !nosof; in_eof = (i == len - 1);
         if (gap > 0) begin
            @(negedge clk); in_valid = 1'b0;
            repeat (gap - 1) @(negedge clk);
         end
      end
      @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      repeat (30) @(negedge clk);
   endtask

   task automatic chk_data(input string req, input int k0, input int len, input int seed);
      int bad = 0;
      for (int i = 0; i < len; i++)
         if (rd_byte(bufa(k0 + i / 128) + 32'(i % 128)) !== pat(seed, i)) bad++;
      chk(req, "frame bytes mismatching", 32'(bad), 32'd0);
   endtask

   task automatic t_reset();
      chk("R12", "irq_status after reset", {29'd0, irq_status}, 32'd0);
      chk("R12", "irq after reset", {31'd0, irq}, 32'd0);
      chk("R12", "mem_req after reset", {31'd0, mem_req}, 32'd0);
   endtask

   task automatic t_short();
      init_ring(4);
      send_frame(60, 3, 1, 1'b0);
      chk("R3", "single piece status", rd(desc(0) + 4), 32'h0000_C03C);
      chk("R2", "address word write-back", rd(desc(0)), bufa(0) | 32'h1);
      chk_data("R1", 0, 60, 1);
      chk("R8", "frame done flag only", {29'd0, irq_status}, 32'd1);
      chk("R9", "irq follows flags", {31'd0, irq}, 32'd1);
      repeat (5) @(negedge clk);
      chk("R9", "flag sticky", {29'd0, irq_status}, 32'd1);
      irq_clr = 3'b001;
      @(negedge clk); irq_clr = 3'b000;
      chk("R9", "flag cleared by write one", {29'd0, irq_status}, 32'd0);
      chk("R9", "irq low after clear", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_multi();
      init_ring(4);
      send_frame(300, 3, 2, 1'b0);
      chk("R3", "first piece status", rd(desc(0) + 4), 32'h0000_4000);
      chk("R3", "middle piece status", rd(desc(1) + 4), 32'h0000_0000);
      chk("R3", "last piece status with length", rd(desc(2) + 4), 32'h0000_812C);
      chk("R4", "unused descriptor untouched", rd(desc(3) + 4), SENT);
      chk("R2", "last piece address word", rd(desc(2)), bufa(2) | 32'h1);
      chk_data("R4", 0, 300, 2);
   endtask

   task automatic t_wrap();
      init_ring(2);
      send_frame(10, 3, 3, 1'b0);
      send_frame(12, 3, 4, 1'b0);
      chk("R2", "wrap bit kept on write-back", rd(desc(1)), bufa(1) | 32'h3);
      tb_write(desc(0), bufa(0));
      clear_flags();
      send_frame(14, 3, 5, 1'b0);
      chk("R5", "frame after wrap lands at ring base", rd(desc(0) + 4), 32'h0000_C00E);
      chk_data("R5", 0, 14, 5);
      chk("R5", "slot past ring end untouched", rd(desc(2) + 4), SENT);
   endtask

   task automatic t_disabled();
      int w0;
      init_ring(4);
      send_frame(8, 3, 6, 1'b0);
      @(negedge clk); rx_en = 1'b0;
      clear_flags();
      w0 = wr_count;
      send_frame(20, 1, 7, 1'b0);
      chk("R10", "no writes while disabled", 32'(wr_count - w0), 32'd0);
      chk("R10", "no flags while disabled", {29'd0, irq_status}, 32'd0);
      tb_write(desc(0), bufa(0));
      @(negedge clk); rx_en = 1'b1;
      send_frame(9, 3, 8, 1'b0);
      chk("R10", "resume at ring base", rd(desc(0) + 4), 32'h0000_C009);
      chk("R10", "second slot untouched", rd(desc(1) + 4), SENT);
   endtask

   task automatic t_stray();
      int w0;
      init_ring(4);
      w0 = wr_count;
      send_frame(6, 2, 9, 1'b1);
      chk("R11", "no writes for bytes outside a frame", 32'(wr_count - w0), 32'd0);
      send_frame(8, 3, 10, 1'b0);
      chk("R11", "next frame in first slot", rd(desc(0) + 4), 32'h0000_C008);
      chk_data("R11", 0, 8, 10);
   endtask

   task automatic t_bna();
      init_ring(4);
      tb_write(desc(1), bufa(1) | 32'h1);
      send_frame(200, 3, 11, 1'b0);
      chk("R6", "unavailable flag only", {29'd0, irq_status}, 32'd2);
      chk("R6", "first piece without end mark", rd(desc(0) + 4), 32'h0000_4000);
      chk("R6", "owned descriptor status untouched", rd(desc(1) + 4), SENT);
      chk("R6", "owned descriptor address untouched", rd(desc(1)), bufa(1) | 32'h1);
      chk("R6", "no advance past owned slot", rd(desc(2) + 4), SENT);
      clear_flags();
      tb_write(desc(1), bufa(1));
      send_frame(12, 3, 12, 1'b0);
      chk("R6", "retry uses same descriptor", rd(desc(1) + 4), 32'h0000_C00C);
      chk_data("R6", 1, 12, 12);
   endtask

   task automatic t_overrun();
      int found = 0;
      init_ring(4);
      send_frame(150, 0, 13, 1'b0);
      send_frame(20, 3, 14, 1'b0);
      chk("R7", "overrun flag", {31'd0, irq_status[2]}, 32'd1);
      chk("R7", "lost frame closed without end mark", rd(desc(0) + 4) & 32'h0000_C000,
          32'h0000_4000);
      for (int k = 1; k < 4; k++)
         if (found == 0 && rd(desc(k) + 4) !== SENT && rd(desc(k) + 4) & 32'h4000) found = k;
      chk("R7", "next frame found in a later slot", {31'd0, found != 0}, 32'd1);
      if (found != 0) begin
         chk("R7", "next frame status", rd(desc(found) + 4), 32'h0000_C014);
         chk_data("R7", found, 20, 14);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short();
      t_multi();
      t_wrap();
      t_disabled();
      t_stray();
      t_bna();
      t_overrun();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule